// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel with a configurable width (16 bits by default). A separate register front end supplies three things: an operating mode code, a reload value and a one-cycle strobe that marks a newly written count. The channel advances only on clock cycles where a one-cycle tick enable is high. It presents the live count, the level of its output pin, and a one-clock event pulse that an interrupt controller can take as an interrupt request.

A write does not start counting at once. The channel first goes pending, and the next tick is used up copying the reload value into the counter. From then on, each tick moves the count down. When the count expires, the mode decides whether the counter takes the programmed value again or wraps to all ones. The mode also decides how the output pin moves and whether an event is signalled. Five behaviours are supported: interrupt at terminal count, one-shot, rate generator, square wave and software strobe. The sixth mode code, and any code above it, parks the channel in the idle state.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is idle, the count is 0, and both out_pin and out_evt are low.
- R2: A load strobe makes the output low for mode 0 and high for modes 1, 2, 3 and 4, starting the cycle after the strobe. The channel then goes pending and the count does not change. The next tick copies the reload value into the count, with no decrement and no event.
- R3: While the channel is running in modes 0, 1, 2 or 4, each tick lowers the count by 1. While the channel is idle, ticks leave the count unchanged.
- R4: A reload value of 0 loads 0xFFFF on the pending tick.
- R5: In mode 0, the first expiry raises out_pin, pulses out_evt and wraps the count to 0xFFFF. In mode 1 the pin is already high, so an expiry reloads the programmed value and gives no event.
- R6: In mode 2, every expiry pulses out_evt and reloads the programmed value. A reload of N therefore gives one event every N ticks, and out_pin stays high.
- R7: In mode 2, a new load while the channel is running in mode 2 neither restarts the count nor leaves the running state. The new value is first used at the next expiry.
- R8: In mode 3, an odd reload value is rounded down to even and the count falls by 2 per tick. Each expiry reloads the count and toggles out_pin. out_evt pulses only on the toggle that drives out_pin high.
- R9: In mode 4, the first expiry drives out_pin low, pulses out_evt and wraps the count to 0xFFFF.
- R10: A load with a mode code of 5 or higher makes the channel idle. Later ticks leave the count unchanged and raise no event.
- R11: When load and tick are high in the same cycle, the load takes effect and that tick is discarded.
- R12: out_evt is high for exactly one clock, in the cycle that follows the tick that caused the expiry. It is never high unless the previous cycle had a tick and no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| load | input | 1 | Count-written strobe from the register front end |
| mode | input | 3 | Operating mode code, sampled with load |
| reload | input | W | Reload value, sampled with load |
| count | output | W | Live counter value |
| out_pin | output | 1 | Output pin level |
| out_evt | output | 1 | One-clock output-event pulse |

## Verification
A count write and a tick can arrive in the same cycle. The bench does this by raising load and tick on the same falling edge while the channel is running. It then checks that the count still holds its old value, which shows the tick was dropped and the channel went pending. Exactly one further tick must then load the new reload value. A rate-generator rewrite is also issued partway through a count. The count must keep decrementing from where it was, and the new value must appear only at the following expiry.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [2:0]   mode,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         out_pin,
  output logic         out_evt
);
  localparam logic [W-1:0] FULL   = '1;
  localparam logic [1:0]   S_IDLE = 2'd0;
  localparam logic [1:0]   S_PEND = 2'd1;
  localparam logic [1:0]   S_RUN  = 2'd2;

  logic [1:0]   st;
  logic [2:0]   cur_mode;
  logic [W-1:0] rld;

  wire          sq        = (cur_mode == 3'd3);
  wire [W-1:0]  rld_even  = sq ? {rld[W-1:1], 1'b0} : rld;
  wire [W-1:0]  start_val = (rld_even == '0) ? FULL : rld_even;
  wire          wrap_full = (cur_mode == 3'd0) || (cur_mode == 3'd4);
  wire [W-1:0]  next_base = wrap_full ? FULL : start_val;
  wire [W-1:0]  step      = sq ? W'(2) : W'(1);
  wire          expire    = (count <= step);
  wire [W-1:0]  carry     = step - count;
  wire [W-1:0]  after_exp = next_base - carry;
  wire          keep_run  = (mode == 3'd2) && (cur_mode == 3'd2) && (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_mode <= 3'd0;
      rld      <= '0;
      count    <= '0;
      out_pin  <= 1'b0;
      out_evt  <= 1'b0;
    end else begin
      out_evt <= 1'b0;
      if (load) begin
        rld      <= reload;
        cur_mode <= mode;
        if (mode > 3'd4) begin
          st <= S_IDLE;
        end else begin
          if (!keep_run) st <= S_PEND;
          out_pin <= (mode != 3'd0);
        end
      end else if (tick) begin
        case (st)
          S_PEND: begin
            count <= start_val;
            st    <= S_RUN;
          end
          S_RUN: begin
            if (!expire) begin
              count <= count - step;
            end else begin
              count <= after_exp;
              case (cur_mode)
                3'd0, 3'd1: if (!out_pin) begin
                  out_pin <= 1'b1;
                  out_evt <= 1'b1;
                end
                3'd2: out_evt <= 1'b1;
                3'd3: begin
                  out_pin <= !out_pin;
                  out_evt <= !out_pin;
                end
                3'd4: if (out_pin) begin
                  out_pin <= 1'b0;
                  out_evt <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module pit_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         load,
  input logic [W-1:0] count,
  input logic         out_pin,
  input logic         out_evt,
  input logic [1:0]   st,
  input logic [2:0]   cur_mode,
  input logic [W-1:0] rld
);
  p_load_holds_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(count)));

  p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |=> (count == $past(count)));

  p_zero_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && tick && !load && rld == '0 && cur_mode != 3'd3) |=> (count == '1));

  p_evt_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_evt) |-> ($past(tick) && !$past(load)));

  p_square_evt_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_evt && cur_mode == 3'd3) |-> out_pin);

  p_strobe_evt_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_evt && cur_mode == 3'd4) |-> !out_pin);
endmodule

bind pit_channel pit_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .count(count),
  .out_pin(out_pin), .out_evt(out_evt), .st(st), .cur_mode(cur_mode), .rld(rld)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] reload = 16'd0;
  logic [15:0] count;
  logic        out_pin, out_evt;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pit_channel #(.W(16)) u_pit_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .mode(mode),
    .reload(reload), .count(count), .out_pin(out_pin), .out_evt(out_evt)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    @(negedge clk); load = 1'b1; mode = m; reload = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 16'd0);
    chk("R1 pin", {15'd0, out_pin}, 16'd0);
    chk("R1 evt", {15'd0, out_evt}, 16'd0);
    do_tick();
    chk("R3 idle ignores tick", count, 16'd0);
  endtask

  task automatic t_rate();
    do_load(3'd2, 16'd3);
    chk("R2 mode2 pin high", {15'd0, out_pin}, 16'd1);
    chk("R2 pending holds count", count, 16'd0);
    do_tick();
    chk("R2 pending tick loads", count, 16'd3);
    chk("R2 no evt on load tick", {15'd0, out_evt}, 16'd0);
    do_tick(); chk("R3 decrement", count, 16'd2);
    do_tick(); chk("R3 decrement", count, 16'd1);
    do_tick();
    chk("R6 evt at expiry", {15'd0, out_evt}, 16'd1);
    chk("R6 reload", count, 16'd3);
    chk("R6 pin high", {15'd0, out_pin}, 16'd1);
    @(negedge clk);
    chk("R12 evt one clock", {15'd0, out_evt}, 16'd0);
    do_load(3'd2, 16'd5);
    chk("R7 rewrite keeps count", count, 16'd3);
    do_tick(); chk("R7 no restart", count, 16'd2);
    do_tick(); chk("R7 no restart", count, 16'd1);
    do_tick();
    chk("R7 new value at reload", count, 16'd5);
    chk("R7 evt", {15'd0, out_evt}, 16'd1);
  endtask

  task automatic t_term();
    do_load(3'd0, 16'd2);
    chk("R2 mode0 pin low", {15'd0, out_pin}, 16'd0);
    do_tick(); chk("R2 load", count, 16'd2);
    do_tick(); chk("R3 decrement", count, 16'd1);
    do_tick();
    chk("R5 pin rises", {15'd0, out_pin}, 16'd1);
    chk("R5 evt", {15'd0, out_evt}, 16'd1);
    chk("R5 wrap", count, 16'hFFFF);
    do_tick(); chk("R5 keeps counting", count, 16'hFFFE);
    do_load(3'd1, 16'd2);
    do_tick(); do_tick(); do_tick();
    chk("R5 oneshot reload", count, 16'd2);
    chk("R5 oneshot no evt", {15'd0, out_evt}, 16'd0);
    chk("R5 oneshot pin", {15'd0, out_pin}, 16'd1);
  endtask

  task automatic t_square();
    do_load(3'd3, 16'd7);
    do_tick(); chk("R8 even load", count, 16'd6);
    do_tick(); chk("R8 step two", count, 16'd4);
    do_tick(); chk("R8 step two", count, 16'd2);
    do_tick();
    chk("R8 toggle low", {15'd0, out_pin}, 16'd0);
    chk("R8 no evt falling", {15'd0, out_evt}, 16'd0);
    chk("R8 reload", count, 16'd6);
    do_tick(); do_tick(); do_tick();
    chk("R8 toggle high", {15'd0, out_pin}, 16'd1);
    chk("R8 evt rising", {15'd0, out_evt}, 16'd1);
  endtask

  task automatic t_strobe();
    do_load(3'd4, 16'd2);
    chk("R2 mode4 pin high", {15'd0, out_pin}, 16'd1);
    do_tick(); do_tick(); do_tick();
    chk("R9 pin low", {15'd0, out_pin}, 16'd0);
    chk("R9 evt", {15'd0, out_evt}, 16'd1);
    chk("R9 wrap", count, 16'hFFFF);
  endtask

  task automatic t_zero_and_idle();
    do_load(3'd2, 16'd0);
    do_tick(); chk("R4 zero is full", count, 16'hFFFF);
    do_tick(); chk("R4 continues", count, 16'hFFFE);
    do_load(3'd5, 16'd9);
    do_tick(); do_tick();
    chk("R10 idle count", count, 16'hFFFE);
    chk("R10 no evt", {15'd0, out_evt}, 16'd0);
  endtask

  task automatic t_collide();
    do_load(3'd2, 16'd9);
    do_tick(); do_tick();
    chk("R11 setup", count, 16'd8);
    @(negedge clk); load = 1'b1; tick = 1'b1; mode = 3'd4; reload = 16'd4;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    chk("R11 tick dropped", count, 16'd8);
    do_tick(); chk("R11 pending load", count, 16'd4);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_term();
    t_square();
    t_strobe();
    t_zero_and_idle();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule